// File: doc/BRIEF.md
# Receive FIFO with Deferred Error Reporting

This block is the receive queue that sits behind a UART deframer. Every received character is pushed together with three per-character condition bits: parity error, framing error and break. The host sees a character's condition bits only when that character is the oldest one in the queue. The bits travel with the data, so a bad character deeper in the queue does not disturb the reporting of the good ones ahead of it. An overrun is different. A character that arrives while the queue has no room is dropped, and a sticky overrun flag goes up on the next clock edge. The flag stays up until the host clears it.

Two level indications serve the interrupt and DMA paths. The high-data-level flag goes up when the fill level is at or above a programmable interrupt threshold. A DMA request is raised only when the fill level reaches a separate DMA threshold, so the DMA engine does not have to handshake for every byte. A receive timeout covers a short final burst that never reaches either threshold. It counts character-time ticks while the queue holds data and nothing is pushed or popped. When it expires, it raises both the high-data-level flag and the DMA request.

Top module: `rxq_err_fifo`

## Requirements
- R1: After reset the queue is empty (empty=1, full=0, level=0) and ovr_err, timeout, hdl and dma_req are all 0.
- R2: Characters leave in the order they were accepted. rd_data always shows the oldest character. A cycle with rd_en high on a non-empty queue removes that character, and level gives the number of stored characters (0 to DEPTH).
- R3: head_par, head_frm and head_brk carry the condition bits stored with the oldest character. They are 0 while the queue is empty, and a flagged character further back in the queue does not affect them.
- R4: A write while the queue is full (level equal to DEPTH) and no read happens in the same cycle drops the character. ovr_err is 1 from the next cycle onward, and level and stored contents are unchanged. ovr_err stays 1 until a cycle with ovr_clr high. When an overrun and ovr_clr happen in the same cycle, the flag ends up set.
- R5: rd_en on an empty queue has no effect: level stays 0 and a later write is read back correctly.
- R6: hdl is 1 exactly when level is greater than or equal to irq_thr, or when timeout is 1. A threshold value of 0 behaves as 1.
- R7: dma_req is 1 exactly when level is greater than or equal to dma_thr, or when timeout is 1. A threshold value of 0 behaves as 1, so dma_req is never 1 on an empty queue.
- R8: timeout becomes 1 once TO_TICKS char_tick pulses have been seen while the queue is non-empty and no character has been accepted or removed. Any accepted write or read, and any empty cycle, clears it and restarts the count.
- R9: A write and a read in the same cycle are both performed, including when the queue is full. In that case no overrun is flagged and level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push one received character |
| wr_data | input | 8 | Character to push |
| wr_par | input | 1 | Parity error seen on this character |
| wr_frm | input | 1 | Framing error seen on this character |
| wr_brk | input | 1 | Break seen on this character |
| rd_en | input | 1 | Remove the oldest character |
| rd_data | output | 8 | Oldest character (0 when empty) |
| head_par | output | 1 | Parity error of the oldest character |
| head_frm | output | 1 | Framing error of the oldest character |
| head_brk | output | 1 | Break on the oldest character |
| level | output | $clog2(DEPTH+1) | Number of stored characters |
| empty | output | 1 | No character stored |
| full | output | 1 | DEPTH characters stored |
| irq_thr | input | $clog2(DEPTH+1) | High-data-level threshold |
| dma_thr | input | $clog2(DEPTH+1) | DMA request threshold |
| char_tick | input | 1 | One pulse per character time |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| ovr_err | output | 1 | Sticky overrun flag |
| hdl | output | 1 | High-data-level indication |
| timeout | output | 1 | Receive timeout expired |
| dma_req | output | 1 | DMA service request |

## Verification
The bench builds the block with DEPTH=8 and TO_TICKS=3 instead of the defaults of 16 and 4. With these values the full boundary, the overrun-while-full case, the overrun/clear collision and a full-queue simultaneous read and write each take only a handful of pushes. The timeout can be shown firing on exactly the third tick and not on the second. The thresholds are exercised at zero, below, at and above the fill level.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [RXQ_DW-1:0] data;
  } rxq_ent_t;

  // Level compare used by both threshold flags; a zero threshold acts as one.
  function automatic logic lvl_meets(input int unsigned lvl, input int unsigned thr);
    int unsigned eff;
    eff = (thr == 0) ? 1 : thr;
    return lvl >= eff;
  endfunction

  // Ring pointer advance with wrap at an arbitrary depth.
  function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  rxq_ent_t      wr_ent,
  output rxq_ent_t      head_ent,
  output logic [LW-1:0] count,
  output logic          empty,
  output logic          full
);
  rxq_ent_t        mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= PW'(ptr_step(32'(wr_ptr), DEPTH));
      if (rd_acc) rd_ptr <= PW'(ptr_step(32'(rd_ptr), DEPTH));
      if (wr_acc && !rd_acc)      count <= count + LW'(1);
      else if (rd_acc && !wr_acc) count <= count - LW'(1);
    end
  end

  assign head_ent = mem[rd_ptr];
  assign empty    = (count == '0);
  assign full     = (count == LW'(DEPTH));

  // R2: the stored count never exceeds the depth
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));

  // R5: a read on an empty queue leaves it empty
  assert_no_read_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !wr_acc |=> empty);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TO_TICKS = 4,
  localparam int CW = $clog2(TO_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  input  logic empty,
  input  logic char_tick,
  output logic timeout
);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   idle_cnt <= '0;
    else if (empty || activity)                   idle_cnt <= '0;
    else if (char_tick && idle_cnt != CW'(TO_TICKS)) idle_cnt <= idle_cnt + CW'(1);
  end

  assign timeout = (idle_cnt == CW'(TO_TICKS));

  // R8: no timeout on an empty queue
  assert_timeout_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !empty);

  // R8: traffic restarts the idle count
  assert_timeout_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !timeout);
endmodule

// File: rtl/rxq_level_flags.sv
module rxq_level_flags
  import rxq_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] irq_thr,
  input  logic [LW-1:0] dma_thr,
  input  logic          timeout,
  output logic          hdl,
  output logic          dma_req
);
  logic irq_lvl_hit, dma_lvl_hit;

  assign irq_lvl_hit = lvl_meets(32'(level), 32'(irq_thr));
  assign dma_lvl_hit = lvl_meets(32'(level), 32'(dma_thr));
  assign hdl     = irq_lvl_hit || timeout;
  assign dma_req = dma_lvl_hit || timeout;

  // R7: a DMA request never stands on an empty queue
  assert_dma_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> level != '0);

  // R6: the level flag accompanies every timeout
  assert_hdl_on_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> hdl);
endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_TICKS = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RXQ_DW-1:0] wr_data,
  input  logic              wr_par,
  input  logic              wr_frm,
  input  logic              wr_brk,
  input  logic              rd_en,
  output logic [RXQ_DW-1:0] rd_data,
  output logic              head_par,
  output logic              head_frm,
  output logic              head_brk,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full,
  input  logic [LW-1:0]     irq_thr,
  input  logic [LW-1:0]     dma_thr,
  input  logic              char_tick,
  input  logic              ovr_clr,
  output logic              ovr_err,
  output logic              hdl,
  output logic              timeout,
  output logic              dma_req
);
  // Named internal events
  logic     wr_acc, rd_acc, ovr_evt, activity;
  rxq_ent_t wr_ent, head_ent;

  assign rd_acc   = rd_en && !empty;
  assign wr_acc   = wr_en && (!full || rd_en);
  assign ovr_evt  = wr_en && full && !rd_en;
  assign activity = wr_acc || rd_acc;

  assign wr_ent = '{brk: wr_brk, frm: wr_frm, par: wr_par, data: wr_data};

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .wr_ent(wr_ent), .head_ent(head_ent), .count(level),
    .empty(empty), .full(full)
  );

  rxq_idle_timer #(.TO_TICKS(TO_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .activity(activity), .empty(empty),
    .char_tick(char_tick), .timeout(timeout)
  );

  rxq_level_flags #(.LW(LW)) flags_i (
    .clk(clk), .rst_n(rst_n), .level(level), .irq_thr(irq_thr),
    .dma_thr(dma_thr), .timeout(timeout), .hdl(hdl), .dma_req(dma_req)
  );

  // Head outputs are quiet while nothing is stored
  assign rd_data  = empty ? '0 : head_ent.data;
  assign head_par = !empty && head_ent.par;
  assign head_frm = !empty && head_ent.frm;
  assign head_brk = !empty && head_ent.brk;

  // Sticky overrun: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_err <= 1'b0;
    else if (ovr_evt) ovr_err <= 1'b1;
    else if (ovr_clr) ovr_err <= 1'b0;
  end

  // R4: an overrun raises the flag on the next edge
  assert_ovr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_err);

  // R4: the flag holds until cleared
  assert_ovr_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && !ovr_clr |=> ovr_err);

  // R4: the dropped character leaves the queue full
  assert_ovr_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> full);

  // R9: a paired read and write keep the level
  assert_pair_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en && !empty |=> $stable(level));
endmodule

// File: tb/rxq_err_fifo_tb.sv
module rxq_err_fifo_tb_top;
  localparam int DEPTH = 8;
  localparam int TO_TICKS = 3;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_par = 0, wr_frm = 0, wr_brk = 0, rd_en = 0;
  logic char_tick = 0, ovr_clr = 0;
  logic [7:0] wr_data = '0;
  logic [LW-1:0] irq_thr = LW'(8), dma_thr = LW'(8);
  logic [7:0] rd_data;
  logic head_par, head_frm, head_brk, empty, full, ovr_err, hdl, timeout, dma_req;
  logic [LW-1:0] level;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  rxq_err_fifo #(.DEPTH(DEPTH), .TO_TICKS(TO_TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_par(wr_par),
    .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_en(rd_en), .rd_data(rd_data),
    .head_par(head_par), .head_frm(head_frm), .head_brk(head_brk), .level(level),
    .empty(empty), .full(full), .irq_thr(irq_thr), .dma_thr(dma_thr),
    .char_tick(char_tick), .ovr_clr(ovr_clr), .ovr_err(ovr_err), .hdl(hdl),
    .timeout(timeout), .dma_req(dma_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_par = p; wr_frm = f; wr_brk = b;
    @(negedge clk);
    wr_en = 0; wr_par = 0; wr_frm = 0; wr_brk = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1);   chk("R1 full", full, 0);
    chk("R1 level", level, 0);   chk("R1 ovr_err", ovr_err, 0);
    chk("R1 timeout", timeout, 0); chk("R1 hdl", hdl, 0);
    chk("R1 dma_req", dma_req, 0);
  endtask

  task automatic t_order();
    push(8'hA1, 0, 0, 0); push(8'hB2, 0, 0, 0); push(8'hC3, 0, 0, 0);
    chk("R2 level 3", level, 3);
    chk("R2 head A1", rd_data, 8'hA1); pop();
    chk("R2 head B2", rd_data, 8'hB2); pop();
    chk("R2 head C3", rd_data, 8'hC3); pop();
    chk("R2 drained", empty, 1);
  endtask

  task automatic t_head_flags();
    push(8'h10, 0, 0, 0); push(8'h20, 1, 0, 0); push(8'h30, 0, 1, 1);
    chk("R3 clean head par", head_par, 0);
    chk("R3 clean head frm", head_frm, 0);
    chk("R3 clean head brk", head_brk, 0);
    pop();
    chk("R3 par head data", rd_data, 8'h20);
    chk("R3 par head par", head_par, 1);
    chk("R3 par head frm", head_frm, 0);
    pop();
    chk("R3 frm head par", head_par, 0);
    chk("R3 frm head frm", head_frm, 1);
    chk("R3 brk head brk", head_brk, 1);
    pop();
    chk("R3 empty flags", {head_par, head_frm, head_brk}, 0);
  endtask

  task automatic t_empty_read();
    pop();
    chk("R5 level after empty read", level, 0);
    chk("R5 still empty", empty, 1);
    push(8'h55, 0, 0, 0);
    chk("R5 level after write", level, 1);
    chk("R5 data after write", rd_data, 8'h55);
    pop();
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i), 0, 0, 0);
    chk("R4 full", full, 1);
    chk("R4 no ovr yet", ovr_err, 0);
    push(8'hEE, 0, 0, 0);
    chk("R4 ovr set", ovr_err, 1);
    chk("R4 level kept", level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4 contents kept", rd_data, 8'h40 + i);
      pop();
    end
    chk("R4 ovr sticky", ovr_err, 1);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk("R4 ovr cleared", ovr_err, 0);
    for (int i = 0; i < DEPTH; i++) push(8'h60 + 8'(i), 0, 0, 0);
    @(negedge clk); wr_en = 1; wr_data = 8'hEF; ovr_clr = 1;
    @(negedge clk); wr_en = 0; ovr_clr = 0;
    chk("R4 set wins over clear", ovr_err, 1);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk("R4 cleared again", ovr_err, 0);
    for (int i = 0; i < DEPTH; i++) pop();
    chk("R4 drained", empty, 1);
  endtask

  task automatic t_simul();
    push(8'h01, 0, 0, 0); push(8'h02, 0, 0, 0);
    @(negedge clk); wr_en = 1; rd_en = 1; wr_data = 8'h03;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R9 level kept", level, 2);
    chk("R9 head advanced", rd_data, 8'h02);
    for (int i = 0; i < DEPTH - 2; i++) push(8'h80 + 8'(i), 0, 0, 0);
    chk("R9 full", full, 1);
    @(negedge clk); wr_en = 1; rd_en = 1; wr_data = 8'h99;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R9 full pair no ovr", ovr_err, 0);
    chk("R9 full pair level", level, DEPTH);
    for (int i = 0; i < DEPTH - 1; i++) pop();
    chk("R9 last is paired write", rd_data, 8'h99);
    pop();
  endtask

  task automatic t_thresholds();
    irq_thr = LW'(3); dma_thr = LW'(5);
    push(8'h11, 0, 0, 0); push(8'h12, 0, 0, 0);
    chk("R6 below irq thr", hdl, 0);
    chk("R7 below dma thr", dma_req, 0);
    push(8'h13, 0, 0, 0);
    chk("R6 at irq thr", hdl, 1);
    chk("R7 below dma thr at 3", dma_req, 0);
    push(8'h14, 0, 0, 0); push(8'h15, 0, 0, 0);
    chk("R7 at dma thr", dma_req, 1);
    pop();
    chk("R7 dropped below thr", dma_req, 0);
    chk("R6 above irq thr", hdl, 1);
    irq_thr = '0; dma_thr = '0;
    for (int i = 0; i < 4; i++) pop();
    #1;
    chk("R6 zero thr empty", hdl, 0);
    chk("R7 zero thr empty", dma_req, 0);
    push(8'h16, 0, 0, 0);
    chk("R6 zero thr acts as one", hdl, 1);
    chk("R7 zero thr acts as one", dma_req, 1);
    pop();
    irq_thr = LW'(8); dma_thr = LW'(8);
  endtask

  task automatic t_timeout();
    for (int i = 0; i < TO_TICKS; i++) tick();
    chk("R8 no timeout when empty", timeout, 0);
    push(8'h21, 0, 0, 0);
    for (int i = 0; i < TO_TICKS - 1; i++) tick();
    chk("R8 one tick short", timeout, 0);
    chk("R7 no dma before timeout", dma_req, 0);
    tick();
    chk("R8 timeout fires", timeout, 1);
    chk("R6 hdl on timeout", hdl, 1);
    chk("R7 dma on timeout", dma_req, 1);
    push(8'h22, 0, 0, 0);
    chk("R8 write clears", timeout, 0);
    for (int i = 0; i < TO_TICKS - 1; i++) tick();
    pop();
    chk("R8 read clears", timeout, 0);
    for (int i = 0; i < TO_TICKS; i++) tick();
    chk("R8 refires after restart", timeout, 1);
    pop();
    chk("R8 empty clears", timeout, 0);
    chk("R7 empty no dma", dma_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_head_flags();
    t_empty_read();
    t_overrun();
    t_simul();
    t_thresholds();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule